// File: doc/BRIEF.md
# Color Lookup Table Loader

This block fills an on-chip color lookup table from a stream of 16-bit words and then serves pixel lookups from it. A start pulse opens a load and selects one of three load modes. The first word after a start is a header that also serves as table entry 0: its top four bits give the pixel depth. That depth sets how many words belong to the load and how pixel indices are masked during lookups. Every word carries a 12-bit color in its low twelve bits, with red in bits 11:8, green in bits 7:4 and blue in bits 3:0.

The lookup port takes a pixel value each cycle and returns, one cycle later, either the table color zero-extended to 16 bits or, in the 12/16 bpp depth, the pixel value unchanged. When a palette-only load has written its last entry the block raises a one-cycle completion pulse. Words that arrive when no load is open, or after the expected count, are consumed and thrown away.

Top module: `clut_loader`

## Requirements
- R1: After reset `done` is 0, `in_ready` is 1, the depth is the 12/16 bpp bypass depth and `px_out` is 0.
- R2: The k-th word accepted after a start (k from 0) writes bits 11:0 into table entry k. A table lookup returns {4'b0, entry}, and bits 15:12 of every word other than the first are ignored.
- R3: Bits 15:12 of the first word select the depth: 0 means 1 bpp, 1 means 2 bpp, 2 means 4 bpp, 3 means 8 bpp and 4 means 12/16 bpp. Codes 0 to 2 load 128 words, code 3 loads 256 words and code 4 loads 16 words. Codes 5 to 15 behave as code 4.
- R4: In palette-only mode `done` is high for exactly one cycle. It rises on the clock edge that accepts the last expected word and is never high earlier.
- R5: Words accepted after the expected count, or with no load open, leave the table and the depth unchanged until the next start.
- R6: At 1, 2, 4 and 8 bpp the lookup index is the low 1, 2, 4 or 8 bits of `px_in`, and higher bits are ignored.
- R7: At the 12/16 bpp depth `px_out` equals `px_in` from the previous cycle, which is the same one-cycle latency as a table lookup.
- R8: `ld_mode` 2'b01 is palette-only: it loads the table and signals `done`. 2'b00 is palette-and-frame: it loads the table without `done`. 2'b10 and 2'b11 are frame-only: they abort any open load, write nothing, keep the depth and give no `done`.
- R9: `in_ready` is low in any cycle where `start` is high and high otherwise. A start during an open load restarts counting at entry 0 with a new header.
- R10: Cycles with `in_valid` low consume nothing, and the count of a load resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a load (one-cycle pulse) |
| ld_mode | input | 2 | Load mode sampled with `start` |
| in_valid | input | 1 | Input word valid |
| in_data | input | 16 | Input word: header/color |
| in_ready | output | 1 | Word accepted when high with `in_valid` |
| px_in | input | 16 | Pixel value to look up |
| px_out | output | 16 | Looked-up color or passed pixel, one cycle later |
| done | output | 1 | Palette-loaded pulse |

## Verification
Loads run at every depth code. This includes an out-of-range code and full 256-word and 128-word loads with surplus words, which separates the per-depth word counts and the discard behaviour. Lookups with high pixel bits set tell the index masking of each depth apart from an unmasked index, and pass-through values distinguish bypass from table reads. Loads with idle gaps, restarts in the middle of a load and a frame-only start after a partial load check the counter, the restart to entry 0 and the abort without a completion pulse. Each mode is checked for whether it gives the completion pulse.

// File: rtl/clut_loader.sv
module clut_loader #(
  parameter int WORD_W    = 16,
  parameter int COLOR_W   = 12,
  parameter int CODE_W    = 4,
  parameter int ENTRIES   = 256,
  parameter int HDR_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        ld_mode,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic [WORD_W-1:0] px_in,
  output logic [WORD_W-1:0] px_out,
  output logic              done
);
  localparam int AW = $clog2(ENTRIES);
  localparam int CW = AW + 1;
  localparam logic [2:0] D_DIRECT = 3'd4;

  logic [COLOR_W-1:0] mem [ENTRIES];
  logic               active, done_en;
  logic [CW-1:0]      cnt, total, hdr_total, goal;
  logic [2:0]         depth, hdr_depth;
  logic               take, first, last;
  logic [AW-1:0]      idx;
  logic [COLOR_W-1:0] rd_q;
  logic [WORD_W-1:0]  pass_q;
  logic               byp_q;

  wire [CODE_W-1:0] hdr_code = in_data[WORD_W-1 -: CODE_W];

  assign in_ready = !start;
  assign take     = in_valid && in_ready && active;
  assign first    = (cnt == '0);

  always_comb begin
    if (hdr_code >= CODE_W'(4)) begin
      hdr_depth = D_DIRECT;
      hdr_total = CW'(HDR_WORDS);
    end else if (hdr_code == CODE_W'(3)) begin
      hdr_depth = 3'd3;
      hdr_total = CW'(ENTRIES);
    end else begin
      hdr_depth = hdr_code[2:0];
      hdr_total = CW'(ENTRIES / 2);
    end
  end

  assign goal = first ? hdr_total : total;
  assign last = (cnt == goal - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      done_en <= 1'b0;
      cnt     <= '0;
      total   <= '0;
      depth   <= D_DIRECT;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active  <= !ld_mode[1];
        done_en <= (ld_mode == 2'b01);
        cnt     <= '0;
      end else if (take) begin
        if (first) begin
          depth <= hdr_depth;
          total <= hdr_total;
        end
        if (last) begin
          active <= 1'b0;
          done   <= done_en;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (take) mem[cnt[AW-1:0]] <= in_data[COLOR_W-1:0];

  always_comb begin
    case (depth)
      3'd0:    idx = AW'(px_in[0]);
      3'd1:    idx = AW'(px_in[1:0]);
      3'd2:    idx = AW'(px_in[3:0]);
      default: idx = px_in[AW-1:0];
    endcase
  end

  always_ff @(posedge clk)
    rd_q <= mem[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_q <= '0;
      byp_q  <= 1'b1;
    end else begin
      pass_q <= px_in;
      byp_q  <= (depth == D_DIRECT);
    end
  end

  assign px_out = byp_q ? pass_q : {{(WORD_W-COLOR_W){1'b0}}, rd_q};
endmodule

module clut_loader_chk #(
  parameter int WORD_W = 16,
  parameter int CW     = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        ld_mode,
  input logic              in_valid,
  input logic              done,
  input logic [WORD_W-1:0] px_in,
  input logic [WORD_W-1:0] px_out,
  input logic [2:0]        depth,
  input logic              active,
  input logic [CW-1:0]     cnt
);
  logic up, armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up    <= 1'b0;
      armed <= 1'b0;
    end else begin
      up <= 1'b1;
      if (start) armed <= (ld_mode == 2'b01);
      else if (done) armed <= 1'b0;
    end
  end

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> armed);

  assert_depth_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= 3'd4);

  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up && $past(depth) == 3'd4) |-> px_out == $past(px_in));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> ($stable(depth) && $stable(cnt)));

  assert_gap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !in_valid && !start) |=> $stable(cnt));
endmodule

bind clut_loader clut_loader_chk #(.WORD_W(WORD_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ld_mode(ld_mode),
  .in_valid(in_valid), .done(done), .px_in(px_in), .px_out(px_out),
  .depth(depth), .active(active), .cnt(cnt)
);

// File: tb/sim_clut_loader.sv
`timescale 1ns/1ps
module sim_clut_loader;
  logic        clk = 1'b0;
  logic        rst_n, start, in_valid, in_ready, done;
  logic [1:0]  ld_mode;
  logic [15:0] in_data, px_in, px_out;

  always #4 clk = ~clk;

  clut_loader u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ld_mode(ld_mode),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .px_in(px_in), .px_out(px_out), .done(done)
  );

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t q[$];

  int errors = 0, checks = 0, done_seen = 0, expd = 0;
  bit finished = 0;
  logic [11:0] model [256];
  int mdepth = 4;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] col(int i, int s);
    return 12'((i * 53 + s * 97 + 11) % 4096);
  endfunction

  function automatic int words_for(int code);
    if (code >= 4) return 16;
    if (code == 3) return 256;
    return 128;
  endfunction

  function automatic logic [15:0] expect_px(logic [15:0] p);
    int m;
    if (mdepth >= 4) return p;
    m = (mdepth == 0) ? 1 : (mdepth == 1) ? 3 : (mdepth == 2) ? 15 : 255;
    return {4'b0, model[int'(p) & m]};
  endfunction

  always @(posedge clk) begin
    #1;
    if (done) done_seen++;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(px_out == it.exp, it.tag, px_out, it.exp);
    end
  end

  task automatic lookup(logic [15:0] p, string tag);
    @(negedge clk);
    px_in = p;
    q.push_back('{expect_px(p), tag});
  endtask

  task automatic do_start(logic [1:0] m);
    @(negedge clk);
    start = 1'b1;
    ld_mode = m;
    #1 chk(in_ready == 1'b0, "R9 ready low during start", in_ready, 0);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(logic [15:0] w);
    in_valid = 1'b1;
    in_data = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic load(int code, int n, logic [1:0] m, int seed, bit gap);
    bit pal;
    int ce;
    pal = !m[1];
    ce = words_for(code);
    do_start(m);
    for (int i = 0; i < n; i++) begin
      send({(i == 0) ? 4'(code) : 4'(i * 5 + 1), col(i, seed)});
      if (pal && i < ce) model[i] = col(i, seed);
      if (pal && i == 0) mdepth = (code >= 4) ? 4 : code;
      if (pal && i == ce - 2)
        chk(done == 1'b0, "R4 no early done", done, 0);
      if (pal && i == ce - 1) begin
        chk(done == (m == 2'b01), "R4 R8 done at last word", done, (m == 2'b01));
        if (m == 2'b01) expd++;
      end
      if (gap) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; ld_mode = 2'b00;
    in_valid = 1'b0; in_data = '0; px_in = '0;
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
    chk(px_out == 16'h0, "R1 reset px_out", px_out, 0);
    lookup(16'hABCD, "R1 R7 bypass after reset");

    load(3, 259, 2'b01, 1, 0);
    lookup(16'h0000, "R2 entry0 color only");
    lookup(16'h007F, "R2 8bpp lookup");
    lookup(16'h00FF, "R2 last entry");
    lookup(16'h03A5, "R6 8bpp high bits ignored");

    load(2, 128, 2'b00, 2, 0);
    lookup(16'h00F5, "R6 4bpp mask");
    lookup(16'h0C3C, "R6 4bpp mask high");

    load(1, 128, 2'b01, 3, 0);
    lookup(16'h003E, "R6 2bpp mask");
    load(0, 128, 2'b01, 4, 0);
    lookup(16'h00FF, "R6 1bpp mask odd");
    lookup(16'h00FE, "R6 1bpp mask even");

    load(4, 20, 2'b01, 5, 1);
    lookup(16'h1234, "R7 bypass 16bpp");
    lookup(16'hFFFF, "R7 bypass all ones");
    load(9, 16, 2'b01, 6, 0);
    lookup(16'h0F0F, "R3 code above 4 bypass");

    load(3, 256, 2'b01, 7, 0);
    load(3, 10, 2'b01, 8, 0);
    load(3, 20, 2'b10, 9, 0);
    load(3, 8, 2'b11, 14, 0);
    lookup(16'h0005, "R8 aborted load kept entry");
    lookup(16'h000F, "R8 frame mode no write");
    lookup(16'h00C8, "R8 frame mode old entry");

    load(3, 5, 2'b01, 10, 0);
    load(4, 16, 2'b01, 11, 0);
    load(3, 1, 2'b01, 13, 0);
    lookup(16'h0003, "R9 restart entries");
    lookup(16'h0014, "R9 untouched entry");
    lookup(16'h0000, "R9 new header entry");

    repeat (4) @(negedge clk);
    chk(done_seen == expd, "R4 R8 done pulse count", done_seen, expd);
    chk(q.size() == 0, "R2 scoreboard drained", q.size(), 0);
    finish_run();
  end
endmodule